// File: doc/BRIEF.md
# DMA Channel Enable, Activity Status and Grant Match

This block holds the per-channel gating state of an eight-channel DMA controller. Each channel has a 4-bit arbitration level, which the host writes and reads back, and one mask bit that enables or disables it. When the system bus is granted, the block compares the winning arbitration level with all eight stored levels. One cycle later it reports which enabled channel should begin its operation. The highest level value is reserved for the default bus master and never selects a channel.

The surrounding sequencer reports events to the block:

- an attention start request enables a channel;
- the completion or failure of an operation disables it again;
- every data transfer marks the channel as active.

Completion also sets a terminal-count flag and pulses a terminal-count output. Both are held back while the channel still has indirect-list entries to fetch. The host reads the inverted mask as a busy byte. It reads the status as two bytes with an interleaved layout, and reading a byte clears that byte. A controller reset restores every mask bit and clears all status. A channel reset clears only the two flags of that channel.

Top module: `dma_chan_gate`

## Requirements
- R1: After `rstN` every stored arbitration level reads back as 4'hF. A write with `levelWrEn` stores `levelWrData` for channel `levelWrChan`, and the value is visible on `levelRdData` from the next cycle.
- R2: A cycle with `grantValid` high makes `startValid` high in the next cycle, with `startChan` naming the channel, only if that channel's stored level equals `grantLevel` and its mask bit is 0. Otherwise `startValid` is low in that next cycle.
- R3: A `grantLevel` of 4'hF never starts a channel, even when an enabled channel stores level F.
- R4: When several enabled channels match the winning level, the lowest-numbered one is started. A matching channel that is masked is skipped in favour of the next enabled match.
- R5: `attnValid` clears the mask bit of `attnChan`. `errValid` sets the mask bit of `errChan`. `doneValid` sets the mask bit of `doneChan` when the channel has no chain pending. If a set and a clear hit the same channel in one cycle, the set wins.
- R6: `busyByte` is the bitwise inverse of the mask, with bit n for channel n. After `rstN` or `ctlReset` the mask is all ones, so `busyByte` is 8'h00.
- R7: Status layout, with channel n given as n. `statusLo` bits 7..4 are the terminal-count flags of channels 3..0, and bits 3..0 are their activity flags. `statusHi` bits 7..4 are the terminal-count flags of channels 7..4, and bits 3..0 are their activity flags. `xferValid` sets the activity flag of `xferChan`.
- R8: A cycle with `statusRdLo` or `statusRdHi` high returns the byte unchanged in that cycle and clears only that byte at the following edge. A flag set in the same cycle as the read of its byte is kept.
- R9: `ctlReset` clears both status bytes, sets the whole mask and drops `startValid`. `chanReset` clears only the terminal-count and activity flags of `chanResetSel`.
- R10: `doneValid` for a channel whose `chainPending` bit is 0 sets its terminal-count flag and pulses `tcOut` high for exactly one cycle. When the `chainPending` bit is 1, no flag, no pulse and no mask change follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlReset | input | 1 | Controller reset command (synchronous) |
| chanReset | input | 1 | Single-channel reset command |
| chanResetSel | input | 3 | Channel addressed by `chanReset` |
| levelWrEn | input | 1 | Write strobe for an arbitration level |
| levelWrChan | input | 3 | Channel whose level is written |
| levelWrData | input | 4 | New arbitration level |
| levelRdChan | input | 3 | Channel whose level is shown |
| levelRdData | output | 4 | Stored level of `levelRdChan` |
| attnValid | input | 1 | Attention start request |
| attnChan | input | 3 | Channel of the start request |
| doneValid | input | 1 | Transfer count of a channel reached zero |
| doneChan | input | 3 | Channel that reached zero |
| errValid | input | 1 | Operation error |
| errChan | input | 3 | Channel that failed |
| xferValid | input | 1 | A data transfer happened |
| xferChan | input | 3 | Channel that transferred |
| chainPending | input | 8 | Per channel: indirect-list entries remain |
| grantValid | input | 1 | Bus grant with a winning level |
| grantLevel | input | 4 | Winning arbitration level |
| startValid | output | 1 | A channel is to begin its operation |
| startChan | output | 3 | Channel that begins |
| tcOut | output | 1 | Terminal-count pulse |
| busyByte | output | 8 | Inverse of the mask |
| statusRdLo | input | 1 | Host reads the low status byte |
| statusRdHi | input | 1 | Host reads the high status byte |
| statusLo | output | 8 | Low status byte |
| statusHi | output | 8 | High status byte |

## Verification
Grant matching is tried with four kinds of input:

- a single enabled match, which shows that level and mask are both compared;
- a match on a masked channel, which shows that the mask gates the start;
- the reserved level stored on an enabled channel, which shows that the exclusion is made on the grant side;
- three channels sharing one level, first with the lowest enabled and then with it masked, which separates lowest-first priority from any other order.

Status is filled from low-half and high-half channels together, so a swapped or shifted bit position shows up as a wrong byte value. Each byte is then read alone, and once together with a new event, which tells a per-byte clear from a whole-register clear and shows whether a same-cycle set survives the clear. Completion is driven once with a chain pending and once without, which separates the suppression of the flag, the pulse and the mask from normal completion.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  parameter int CH_COUNT = 8;
  parameter int LEVEL_W  = 4;
  localparam int SEL_W   = $clog2(CH_COUNT);
  localparam int HALF    = CH_COUNT / 2;
  localparam logic [LEVEL_W-1:0] RESERVED_LVL = '1;

  typedef struct packed {
    logic [CH_COUNT-1:0] maskSet;
    logic [CH_COUNT-1:0] maskClr;
    logic [CH_COUNT-1:0] tcSet;
    logic [CH_COUNT-1:0] rqSet;
    logic [CH_COUNT-1:0] chanClr;
    logic                allClr;
    logic                rdLo;
    logic                rdHi;
    logic                tcFire;
  } gateStrobes_t;
endpackage

// File: rtl/dcg_ctrl.sv
module dcg_ctrl
  import dcg_pkg::*;
(
  input  logic                ctlReset,
  input  logic                chanReset,
  input  logic [SEL_W-1:0]    chanResetSel,
  input  logic                attnValid,
  input  logic [SEL_W-1:0]    attnChan,
  input  logic                doneValid,
  input  logic [SEL_W-1:0]    doneChan,
  input  logic                errValid,
  input  logic [SEL_W-1:0]    errChan,
  input  logic                xferValid,
  input  logic [SEL_W-1:0]    xferChan,
  input  logic [CH_COUNT-1:0] chainPending,
  input  logic                statusRdLo,
  input  logic                statusRdHi,
  output gateStrobes_t        str
);
  logic                doneFinal;
  logic [CH_COUNT-1:0] attnHit;
  logic [CH_COUNT-1:0] doneHit;
  logic [CH_COUNT-1:0] errHit;
  logic [CH_COUNT-1:0] xferHit;
  logic [CH_COUNT-1:0] rstHit;

  // completion only ends the operation when no list entry remains
  assign doneFinal = doneValid && !chainPending[doneChan];

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_dec
    assign attnHit[c] = attnValid && (attnChan == SEL_W'(c));
    assign doneHit[c] = doneFinal && (doneChan == SEL_W'(c));
    assign errHit[c]  = errValid  && (errChan  == SEL_W'(c));
    assign xferHit[c] = xferValid && (xferChan == SEL_W'(c));
    assign rstHit[c]  = chanReset && (chanResetSel == SEL_W'(c));
  end

  always_comb begin
    str         = '0;
    str.allClr  = ctlReset;
    str.maskClr = attnHit;
    str.maskSet = doneHit | errHit;
    str.tcSet   = doneHit;
    str.rqSet   = xferHit;
    str.chanClr = rstHit;
    str.rdLo    = statusRdLo;
    str.rdHi    = statusRdHi;
    str.tcFire  = doneFinal;
  end
endmodule

// File: rtl/dcg_datapath.sv
module dcg_datapath
  import dcg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  gateStrobes_t        str,
  input  logic                levelWrEn,
  input  logic [SEL_W-1:0]    levelWrChan,
  input  logic [LEVEL_W-1:0]  levelWrData,
  input  logic [SEL_W-1:0]    levelRdChan,
  output logic [LEVEL_W-1:0]  levelRdData,
  input  logic                grantValid,
  input  logic [LEVEL_W-1:0]  grantLevel,
  output logic                startValid,
  output logic [SEL_W-1:0]    startChan,
  output logic                tcOut,
  output logic [CH_COUNT-1:0] maskBits,
  output logic [CH_COUNT-1:0] tcFlags,
  output logic [CH_COUNT-1:0] rqFlags
);
  logic [LEVEL_W-1:0]  levels [CH_COUNT];
  logic [CH_COUNT-1:0] hit;
  logic                anyHit;
  logic [SEL_W-1:0]    pick;
  logic [CH_COUNT-1:0] byteKeep;
  logic [CH_COUNT-1:0] maskNext;
  logic [CH_COUNT-1:0] tcNext;
  logic [CH_COUNT-1:0] rqNext;

  // parallel comparators; the reserved level is excluded on the grant side
  for (genvar c = 0; c < CH_COUNT; c++) begin : g_match
    assign hit[c] = grantValid && (grantLevel != RESERVED_LVL)
                    && (levels[c] == grantLevel) && !maskBits[c];
  end

  assign anyHit = |hit;

  // lowest channel wins: scan downward so the last assignment is the lowest
  always_comb begin
    pick = '0;
    for (int c = CH_COUNT - 1; c >= 0; c--) begin
      if (hit[c]) pick = SEL_W'(c);
    end
  end

  // per-byte read clear; the low byte owns the low half of the channels
  always_comb begin
    byteKeep = '1;
    if (str.rdLo) byteKeep[HALF-1:0] = '0;
    if (str.rdHi) byteKeep[CH_COUNT-1:HALF] = '0;
  end

  always_comb begin
    maskNext = (maskBits & ~str.maskClr) | str.maskSet;
    tcNext   = ((tcFlags & byteKeep) | str.tcSet) & ~str.chanClr;
    rqNext   = ((rqFlags & byteKeep) | str.rqSet) & ~str.chanClr;
    if (str.allClr) begin
      maskNext = '1;
      tcNext   = '0;
      rqNext   = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskBits   <= '1;
      tcFlags    <= '0;
      rqFlags    <= '0;
      startValid <= 1'b0;
      startChan  <= '0;
      tcOut      <= 1'b0;
    end else begin
      maskBits   <= maskNext;
      tcFlags    <= tcNext;
      rqFlags    <= rqNext;
      startValid <= anyHit && !str.allClr;
      startChan  <= pick;
      tcOut      <= str.tcFire && !str.allClr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CH_COUNT; c++) levels[c] <= RESERVED_LVL;
    end else if (levelWrEn) begin
      levels[levelWrChan] <= levelWrData;
    end
  end

  assign levelRdData = levels[levelRdChan];

  // R3: the reserved level never produces a start
  a_r3_reserved_level_idle: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantLevel == RESERVED_LVL) |=> !startValid);

  // R2: a start only follows a grant
  a_r2_start_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> $past(grantValid));

  // R9: a controller reset leaves no status behind
  a_r9_ctl_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    str.allClr |=> (tcFlags == '0 && rqFlags == '0 && !startValid));

  // R10: the terminal-count pulse lasts one cycle unless completion repeats
  a_r10_tc_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (tcOut && !str.tcFire) |=> !tcOut);
endmodule

// File: rtl/dma_chan_gate.sv
module dma_chan_gate
  import dcg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctlReset,
  input  logic                chanReset,
  input  logic [SEL_W-1:0]    chanResetSel,
  input  logic                levelWrEn,
  input  logic [SEL_W-1:0]    levelWrChan,
  input  logic [LEVEL_W-1:0]  levelWrData,
  input  logic [SEL_W-1:0]    levelRdChan,
  output logic [LEVEL_W-1:0]  levelRdData,
  input  logic                attnValid,
  input  logic [SEL_W-1:0]    attnChan,
  input  logic                doneValid,
  input  logic [SEL_W-1:0]    doneChan,
  input  logic                errValid,
  input  logic [SEL_W-1:0]    errChan,
  input  logic                xferValid,
  input  logic [SEL_W-1:0]    xferChan,
  input  logic [CH_COUNT-1:0] chainPending,
  input  logic                grantValid,
  input  logic [LEVEL_W-1:0]  grantLevel,
  output logic                startValid,
  output logic [SEL_W-1:0]    startChan,
  output logic                tcOut,
  output logic [CH_COUNT-1:0] busyByte,
  input  logic                statusRdLo,
  input  logic                statusRdHi,
  output logic [CH_COUNT-1:0] statusLo,
  output logic [CH_COUNT-1:0] statusHi
);
  gateStrobes_t        str;
  logic [CH_COUNT-1:0] maskBits;
  logic [CH_COUNT-1:0] tcFlags;
  logic [CH_COUNT-1:0] rqFlags;

  dcg_ctrl u_ctrl (
    .ctlReset(ctlReset), .chanReset(chanReset), .chanResetSel(chanResetSel),
    .attnValid(attnValid), .attnChan(attnChan),
    .doneValid(doneValid), .doneChan(doneChan),
    .errValid(errValid), .errChan(errChan),
    .xferValid(xferValid), .xferChan(xferChan),
    .chainPending(chainPending),
    .statusRdLo(statusRdLo), .statusRdHi(statusRdHi),
    .str(str)
  );

  dcg_datapath u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .levelWrEn(levelWrEn), .levelWrChan(levelWrChan), .levelWrData(levelWrData),
    .levelRdChan(levelRdChan), .levelRdData(levelRdData),
    .grantValid(grantValid), .grantLevel(grantLevel),
    .startValid(startValid), .startChan(startChan), .tcOut(tcOut),
    .maskBits(maskBits), .tcFlags(tcFlags), .rqFlags(rqFlags)
  );

  assign busyByte = ~maskBits;
  assign statusLo = {tcFlags[HALF-1:0], rqFlags[HALF-1:0]};
  assign statusHi = {tcFlags[CH_COUNT-1:HALF], rqFlags[CH_COUNT-1:HALF]};

  // R6: busy byte reads zero right after a controller reset
  a_r6_reset_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    ctlReset |=> busyByte == '0);

  // R5: an error disables the failing channel
  a_r5_err_disables: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !ctlReset) |=> !busyByte[$past(errChan)]);

  // R10: a completion with a chain pending raises no pulse
  a_r10_chain_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && chainPending[doneChan]) |=> !tcOut);

  // R8: an activity set in the cycle of a low-byte read survives
  a_r8_set_survives_read: assert property (@(posedge clk) disable iff (!rstN)
    (statusRdLo && xferValid && !xferChan[SEL_W-1] && !ctlReset && !chanReset)
    |=> statusLo[$past(xferChan)]);
endmodule

// File: tb/dma_chan_gate_bench.sv
`timescale 1ns/1ps
module dma_chan_gate_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlReset = 0, chanReset = 0;
  logic [2:0] chanResetSel = 0;
  logic       levelWrEn = 0;
  logic [2:0] levelWrChan = 0;
  logic [3:0] levelWrData = 0;
  logic [2:0] levelRdChan = 0;
  logic [3:0] levelRdData;
  logic       attnValid = 0, doneValid = 0, errValid = 0, xferValid = 0;
  logic [2:0] attnChan = 0, doneChan = 0, errChan = 0, xferChan = 0;
  logic [7:0] chainPending = 0;
  logic       grantValid = 0;
  logic [3:0] grantLevel = 0;
  logic       startValid;
  logic [2:0] startChan;
  logic       tcOut;
  logic [7:0] busyByte;
  logic       statusRdLo = 0, statusRdHi = 0;
  logic [7:0] statusLo, statusHi;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_chan_gate u_dma_chan_gate (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_level(input int ch, input int lv);
    levelWrEn = 1; levelWrChan = 3'(ch); levelWrData = 4'(lv);
    tick();
    levelWrEn = 0;
  endtask

  task automatic attn(input int ch);
    attnValid = 1; attnChan = 3'(ch);
    tick();
    attnValid = 0;
  endtask

  task automatic grant(input int lv);
    grantValid = 1; grantLevel = 4'(lv);
    tick();
    grantValid = 0;
  endtask

  task automatic clear_status();
    statusRdLo = 1; statusRdHi = 1;
    tick();
    statusRdLo = 0; statusRdHi = 0;
  endtask

  task automatic t_reset();
    check("R6 busy after reset", busyByte, 8'h00);
    check("R9 statusLo after reset", statusLo, 0);
    check("R9 statusHi after reset", statusHi, 0);
    check("R2 no start after reset", startValid, 0);
    for (int c = 0; c < 8; c++) begin
      levelRdChan = 3'(c); #1;
      check("R1 level resets to F", levelRdData, 4'hF);
    end
  endtask

  task automatic t_levels();
    for (int c = 0; c < 8; c++) wr_level(c, c + 1);
    for (int c = 0; c < 8; c++) begin
      levelRdChan = 3'(c); #1;
      check("R1 level readback", levelRdData, c + 1);
    end
  endtask

  task automatic t_start();
    attn(2);
    check("R5 attention enables ch2", busyByte, 8'h04);
    check("R6 busy is inverse mask", busyByte, 8'h04);
    grant(3);
    check("R2 start on enabled match", startValid, 1);
    check("R2 started channel", startChan, 2);
    tick();
    check("R2 no start without grant", startValid, 0);
    grant(5);
    check("R2 masked match does not start", startValid, 0);
  endtask

  task automatic t_level_f();
    wr_level(2, 4'hF);
    grant(4'hF);
    check("R3 reserved level never starts", startValid, 0);
    wr_level(2, 3);
  endtask

  task automatic t_priority();
    wr_level(5, 3);
    wr_level(6, 3);
    attn(6);
    attn(5);
    grant(3);
    check("R4 lowest enabled match", startChan, 2);
    check("R4 start valid", startValid, 1);
    doneValid = 1; doneChan = 2;
    tick();
    doneValid = 0;
    check("R10 tc pulse on final done", tcOut, 1);
    check("R5 done disables ch2", busyByte, 8'h60);
    grant(3);
    check("R10 tc pulse one cycle", tcOut, 0);
    check("R4 masked lowest skipped", startChan, 5);
    check("R4 start valid after skip", startValid, 1);
  endtask

  task automatic t_mask();
    attnValid = 1; attnChan = 6; errValid = 1; errChan = 6;
    tick();
    attnValid = 0; errValid = 0;
    check("R5 set wins over clear", busyByte, 8'h20);
    errValid = 1; errChan = 5;
    tick();
    errValid = 0;
    check("R5 error disables ch5", busyByte, 8'h00);
  endtask

  task automatic t_status();
    clear_status();
    xferValid = 1; xferChan = 1; doneValid = 1; doneChan = 0;
    tick();
    xferChan = 6; doneChan = 5;
    tick();
    xferValid = 0; doneValid = 0;
    check("R7 low byte layout", statusLo, 8'h12);
    check("R7 high byte layout", statusHi, 8'h24);
    statusRdLo = 1; #1;
    check("R8 read returns byte", statusLo, 8'h12);
    tick();
    statusRdLo = 0;
    check("R8 low byte cleared", statusLo, 8'h00);
    check("R8 high byte kept", statusHi, 8'h24);
    statusRdHi = 1; xferValid = 1; xferChan = 7;
    tick();
    statusRdHi = 0; xferValid = 0;
    check("R8 same-cycle set survives", statusHi, 8'h08);
    check("R8 low byte untouched", statusLo, 8'h00);
  endtask

  task automatic t_chain();
    clear_status();
    attn(3);
    chainPending = 8'h08; doneValid = 1; doneChan = 3;
    tick();
    doneValid = 0;
    check("R10 no pulse with chain pending", tcOut, 0);
    check("R10 no flag with chain pending", statusLo, 8'h00);
    check("R10 mask kept with chain pending", busyByte, 8'h08);
    chainPending = 8'h00; doneValid = 1;
    tick();
    doneValid = 0;
    check("R10 pulse on final done", tcOut, 1);
    check("R10 flag on final done", statusLo, 8'h80);
    check("R10 mask set on final done", busyByte, 8'h00);
  endtask

  task automatic t_resets();
    clear_status();
    xferValid = 1; xferChan = 1; doneValid = 1; doneChan = 1;
    tick();
    doneValid = 0; xferChan = 2;
    tick();
    xferChan = 5;
    tick();
    xferValid = 0;
    check("R7 combined low byte", statusLo, 8'h26);
    chanReset = 1; chanResetSel = 1;
    tick();
    chanReset = 0;
    check("R9 channel reset clears its flags only", statusLo, 8'h04);
    check("R9 channel reset leaves high byte", statusHi, 8'h02);
    attn(0);
    check("R5 attention enables ch0", busyByte, 8'h01);
    ctlReset = 1; grantValid = 1; grantLevel = 1;
    tick();
    ctlReset = 0; grantValid = 0;
    check("R9 controller reset clears low byte", statusLo, 0);
    check("R9 controller reset clears high byte", statusHi, 0);
    check("R6 controller reset sets mask", busyByte, 8'h00);
    check("R9 controller reset drops start", startValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    t_reset();
    t_levels();
    t_start();
    t_level_f();
    t_priority();
    t_mask();
    t_status();
    t_chain();
    t_resets();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule